// File: doc/BRIEF.md
# Calibrated Seconds Divider

This block turns a stream of oscillator enables, nominally 32,768 per second, into a one-cycle seconds tick and a minute strobe. A signed calibration field trims timekeeping digitally: over a repeating cycle of 64 minutes, the first second of each of the first 2×N minutes is made shorter (when the clock runs slow) or longer (when it runs fast). The crystal is not touched. The calendar counters downstream consume the seconds tick. The minute strobe advances whatever tracks the minute cycle.

The block also drives a frequency-test output that follows a fixed 512 Hz square wave at nominal rate. That output appears only when a set of qualifier inputs allows it. A stop input freezes the divider. A clear input restarts the whole chain, which is what a write to a clock register should do. The divider length is a parameter. The bench scales the second down to 1,024 enables and the minute down to two seconds, so that a full 64-minute cycle fits in one run.

Top module: `cal_second_divider`

## Requirements
- R1: During and right after reset, sec_tick, min_strobe and ft_out are low. The divider, the second index, the minute position and the sampled calibration are all zero.
- R2: With a calibration magnitude of 0, sec_tick pulses high for exactly one cycle after every 2^DIV_W counted enables.
- R3: min_strobe is high only together with sec_tick, on every SEC_PER_MIN-th tick.
- R4: cal_cfg[5]=1 means speed up. For a magnitude N in cal_cfg[4:0], the first second of each of minutes 0 to 2N−1 of the cycle lasts 2^DIV_W − 2^DIV_W/128 enables (32,512 at default size).
- R5: cal_cfg[5]=0 with magnitude N stretches the same seconds to 2^DIV_W + 2^DIV_W/256 enables (32,896 at default size).
- R6: The minute position runs 0 to 63 and wraps to 0. Minutes 2N through 63 always use the nominal length.
- R7: cal_cfg is sampled only when a minute ends and at clear. A change in the middle of a minute leaves the current minute's seconds unchanged.
- R8: While stop_osc is high, no enable is counted and no tick appears. After release, counting resumes from the held count.
- R9: A div_clear cycle zeroes the divider, the second index and the minute position, and samples cal_cfg. No tick appears in the cycle after it.
- R10: ft_out equals bit DIV_W−10 of the counted-enable phase (a 512 Hz square wave at default size) when stop_osc=0, ft_en=1, alarm_irq_en=0, and either wd_steer=0 or wd_zero=1. Otherwise ft_out is low.
- R11: The ft_out waveform keeps the same period and phase through shortened and stretched seconds.
- R12: A cycle with osc_en low advances nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One oscillator period elapsed |
| stop_osc | input | 1 | Halt the divider |
| cal_cfg | input | 6 | [5] speed-up sign, [4:0] magnitude |
| ft_en | input | 1 | Frequency-test request |
| alarm_irq_en | input | 1 | Alarm interrupt enabled (blocks the test output) |
| wd_steer | input | 1 | Watchdog steered to the interrupt pin |
| wd_zero | input | 1 | Watchdog register is zero |
| div_clear | input | 1 | Restart the divider chain |
| sec_tick | output | 1 | One-cycle seconds pulse |
| min_strobe | output | 1 | One-cycle minute pulse |
| ft_out | output | 1 | Frequency-test square wave |

## Verification
The divider first runs at magnitude zero with a continuous enable and then with a random gapped enable. Comparing these two runs shows whether the divider counts enables or clock cycles. A positive magnitude of 3 is run through one complete 64-minute wrap and into the next cycle. This shows the boundary between adjusted and unadjusted minutes, and whether the schedule restarts after the wrap. A negative magnitude of 31 is run with a calibration change in the middle of a minute. This separates the long-second length from the short one and checks that a new value waits for the minute boundary. Stop, a mid-second clear and every qualifier combination of the test output round off the run, while the square wave is checked against a plain count of enables on every cycle.

// File: rtl/rtccal_pkg.sv
package rtccal_pkg;

   localparam int unsigned CYCLE_MINUTES = 64;
   localparam int unsigned MAG_W         = 5;

   typedef struct packed {
      logic             speed_up;
      logic [MAG_W-1:0] mag;
   } cal_word_t;

   typedef enum logic [1:0] {
      SEC_NOMINAL = 2'd0,
      SEC_SHORT   = 2'd1,
      SEC_LONG    = 2'd2
   } sec_len_e;

endpackage

// File: rtl/rtccal_prescaler.sv
module rtccal_prescaler
   import rtccal_pkg::*;
#(
   parameter int unsigned DIV_W = 15
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     adv_i,
   input  logic     clear_i,
   input  sec_len_e len_sel_i,
   output logic     wrap_o,
   output logic     ft_phase_o
);
   localparam int unsigned CNT_W     = DIV_W + 1;
   localparam int unsigned NOM       = 1 << DIV_W;
   localparam int unsigned SHORT_CUT = NOM / 128;
   localparam int unsigned LONG_ADD  = NOM / 256;
   localparam int unsigned FT_BIT    = DIV_W - 10;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;

   always_comb begin
      unique case (len_sel_i)
         SEC_SHORT: term = CNT_W'(NOM - SHORT_CUT - 1);
         SEC_LONG:  term = CNT_W'(NOM + LONG_ADD - 1);
         default:   term = CNT_W'(NOM - 1);
      endcase
   end

   assign wrap_o     = adv_i & (cnt_q == term);
   assign ft_phase_o = cnt_q[FT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/rtccal_schedule.sv
module rtccal_schedule
   import rtccal_pkg::*;
#(
   parameter int unsigned SEC_PER_MIN = 60
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clear_i,
   input  logic      sec_wrap_i,
   input  cal_word_t cal_i,
   output sec_len_e  len_sel_o,
   output logic      min_wrap_o
);
   localparam int unsigned MPOS_W   = $clog2(CYCLE_MINUTES);
   localparam int unsigned LAST_MIN = CYCLE_MINUTES - 1;

   logic              first_sec;
   logic [MPOS_W-1:0] mpos_q;
   cal_word_t         cal_q;
   logic              adjust;

   generate
      if (SEC_PER_MIN == 1) begin : g_one_sec
         assign first_sec  = 1'b1;
         assign min_wrap_o = sec_wrap_i;
      end else begin : g_sec_cnt
         localparam int unsigned SEC_W = $clog2(SEC_PER_MIN);
         logic [SEC_W-1:0] sec_q;
         logic             sec_last;

         assign sec_last   = (sec_q == SEC_W'(SEC_PER_MIN - 1));
         assign first_sec  = (sec_q == '0);
         assign min_wrap_o = sec_wrap_i & sec_last;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sec_q <= '0;
            end else if (clear_i) begin
               sec_q <= '0;
            end else if (sec_wrap_i) begin
               sec_q <= sec_last ? '0 : sec_q + SEC_W'(1);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mpos_q <= '0;
         cal_q  <= '0;
      end else if (clear_i) begin
         mpos_q <= '0;
         cal_q  <= cal_i;
      end else if (min_wrap_o) begin
         mpos_q <= (mpos_q == MPOS_W'(LAST_MIN)) ? '0 : mpos_q + MPOS_W'(1);
         cal_q  <= cal_i;
      end
   end

   assign adjust = first_sec & (mpos_q < {cal_q.mag, 1'b0});

   always_comb begin
      if (!adjust)            len_sel_o = SEC_NOMINAL;
      else if (cal_q.speed_up) len_sel_o = SEC_SHORT;
      else                    len_sel_o = SEC_LONG;
   end

endmodule

// File: rtl/rtccal_freq_test.sv
module rtccal_freq_test (
   input  logic phase_i,
   input  logic stop_i,
   input  logic ft_en_i,
   input  logic afe_i,
   input  logic wds_i,
   input  logic wd_zero_i,
   output logic ft_o
);
   logic allow;

   assign allow = ~stop_i & ft_en_i & ~afe_i & (~wds_i | wd_zero_i);
   assign ft_o  = allow & phase_i;

endmodule

// File: rtl/cal_second_divider.sv
module cal_second_divider
   import rtccal_pkg::*;
#(
   parameter int unsigned DIV_W       = 15,
   parameter int unsigned SEC_PER_MIN = 60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_en,
   input  logic       stop_osc,
   input  logic [5:0] cal_cfg,
   input  logic       ft_en,
   input  logic       alarm_irq_en,
   input  logic       wd_steer,
   input  logic       wd_zero,
   input  logic       div_clear,
   output logic       sec_tick,
   output logic       min_strobe,
   output logic       ft_out
);
   generate
      if (DIV_W < 10 || DIV_W > 24) begin : g_bad_div_w
         $error("DIV_W must lie between 10 and 24");
      end
      if (SEC_PER_MIN < 1) begin : g_bad_spm
         $error("SEC_PER_MIN must be at least 1");
      end
   endgenerate

   cal_word_t cal_in;
   sec_len_e  len_sel;
   logic      adv;
   logic      sec_wrap;
   logic      min_wrap;
   logic      ft_phase;
   logic      sec_tick_q;
   logic      min_strobe_q;

   assign cal_in = cal_word_t'(cal_cfg);
   assign adv    = osc_en & ~stop_osc & ~div_clear;

   rtccal_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_i      (adv),
      .clear_i    (div_clear),
      .len_sel_i  (len_sel),
      .wrap_o     (sec_wrap),
      .ft_phase_o (ft_phase)
   );

   rtccal_schedule #(.SEC_PER_MIN(SEC_PER_MIN)) u_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (div_clear),
      .sec_wrap_i (sec_wrap),
      .cal_i      (cal_in),
      .len_sel_o  (len_sel),
      .min_wrap_o (min_wrap)
   );

   rtccal_freq_test u_ft (
      .phase_i   (ft_phase),
      .stop_i    (stop_osc),
      .ft_en_i   (ft_en),
      .afe_i     (alarm_irq_en),
      .wds_i     (wd_steer),
      .wd_zero_i (wd_zero),
      .ft_o      (ft_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_tick_q   <= 1'b0;
         min_strobe_q <= 1'b0;
      end else begin
         sec_tick_q   <= sec_wrap;
         min_strobe_q <= min_wrap;
      end
   end

   assign sec_tick   = sec_tick_q;
   assign min_strobe = min_strobe_q;

endmodule

// File: rtl/cal_second_divider_chk.sv
module cal_second_divider_chk (
   input logic clk,
   input logic rst_n,
   input logic osc_en,
   input logic stop_osc,
   input logic ft_en,
   input logic alarm_irq_en,
   input logic wd_steer,
   input logic wd_zero,
   input logic div_clear,
   input logic sec_tick,
   input logic min_strobe,
   input logic ft_out
);
   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick); // R2
   AST_MIN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      min_strobe |-> sec_tick); // R3
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      stop_osc |=> !sec_tick && !min_strobe); // R8
   AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      div_clear |=> !sec_tick && !min_strobe); // R9
   AST_FT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_osc || !ft_en || alarm_irq_en || (wd_steer && !wd_zero)) |-> !ft_out); // R10
   AST_FT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && !div_clear && $stable(ft_en) && $stable(alarm_irq_en) && $stable(stop_osc)
       && $stable(wd_steer) && $stable(wd_zero)) |=> $stable(ft_out)); // R12
   AST_NO_EN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |=> !sec_tick); // R12
endmodule

bind cal_second_divider cal_second_divider_chk u_chk (.*);

// File: tb/cal_second_divider_test.sv
module cal_second_divider_test;
   localparam int DIV_W = 10;
   localparam int SPM   = 2;
   localparam int NOM   = 1 << DIV_W;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_en = 1'b0;
   logic       stop_osc = 1'b0;
   logic [5:0] cal_cfg = 6'd0;
   logic       ft_en = 1'b0;
   logic       alarm_irq_en = 1'b0;
   logic       wd_steer = 1'b0;
   logic       wd_zero = 1'b0;
   logic       div_clear = 1'b0;
   logic       sec_tick;
   logic       min_strobe;
   logic       ft_out;

   int checks = 0;
   int fails = 0;
   string cur_req = "R1";
   string ft_req = "R10";

   always #2 clk = ~clk;

   cal_second_divider #(.DIV_W(DIV_W), .SEC_PER_MIN(SPM)) uut (.*);

   // behavioural reference
   int  m_cyc = 0, m_sec = 0, m_mpos = 0, m_mag = 0, m_adv = 0;
   bit  m_sign = 0, m_tick = 0, m_min = 0;

   function automatic int sec_len();
      if (m_sec == 0 && m_mpos < 2 * m_mag)
         return m_sign ? NOM - NOM / 128 : NOM + NOM / 256;
      return NOM;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cyc = 0; m_sec = 0; m_mpos = 0; m_mag = 0; m_sign = 0;
         m_adv = 0; m_tick = 0; m_min = 0;
      end else if (div_clear) begin
         m_cyc = 0; m_sec = 0; m_mpos = 0; m_adv = 0;
         m_sign = cal_cfg[5]; m_mag = int'(cal_cfg[4:0]);
         m_tick = 0; m_min = 0;
      end else begin
         m_tick = 0; m_min = 0;
         if (osc_en && !stop_osc) begin
            m_adv = m_adv + 1;
            if (m_cyc == sec_len() - 1) begin
               m_cyc = 0; m_tick = 1;
               m_sec = m_sec + 1;
               if (m_sec == SPM) begin
                  m_sec = 0; m_min = 1;
                  m_mpos = (m_mpos + 1) % 64;
                  m_sign = cal_cfg[5]; m_mag = int'(cal_cfg[4:0]);
               end
            end else begin
               m_cyc = m_cyc + 1;
            end
         end
      end
   end

   task automatic check(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         bit allow;
         allow = !stop_osc && ft_en && !alarm_irq_en && (!wd_steer || wd_zero);
         check(cur_req, "sec_tick", sec_tick, m_tick);
         check("R3", "min_strobe", min_strobe, m_min);
         check(ft_req, "ft_out", ft_out, allow && (((m_adv >> (DIV_W - 10)) & 1) == 1));
      end
   end

   task automatic run(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse_clear();
      div_clear = 1'b1;
      run(1);
      div_clear = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #5;
      check("R1", "sec_tick in reset", sec_tick, 1'b0);
      check("R1", "min_strobe in reset", min_strobe, 1'b0);
      check("R1", "ft_out in reset", ft_out, 1'b0);
      run(3);
      rst_n = 1'b1;
      run(1);
      check("R1", "sec_tick after reset", sec_tick, 1'b0);
      // nominal, continuous enable, test output on
      cur_req = "R2"; ft_req = "R10";
      osc_en = 1'b1; ft_en = 1'b1;
      run(3 * NOM + 100);
      // gapped enable
      cur_req = "R12";
      for (int i = 0; i < 2500; i++) begin
         osc_en = 1'($urandom % 2);
         run(1);
      end
      osc_en = 1'b1;
      // speed-up by 3 over a full cycle wrap
      cur_req = "R4"; ft_req = "R11";
      cal_cfg = 6'b10_0011;
      pulse_clear();
      run(64 * SPM * NOM);
      cur_req = "R6";
      run(4 * NOM);
      // slow-down by 31, mid-minute change
      cur_req = "R5";
      cal_cfg = 6'b01_1111;
      pulse_clear();
      run(300);
      cur_req = "R7";
      cal_cfg = 6'b00_0000;
      run(2 * SPM * NOM);
      cur_req = "R5";
      cal_cfg = 6'b01_1111;
      run(4 * NOM);
      // stop and resume
      cur_req = "R8"; ft_req = "R10";
      stop_osc = 1'b1;
      run(600);
      stop_osc = 1'b0;
      run(NOM + 200);
      // qualifier combinations
      ft_en = 1'b0;        run(200);
      ft_en = 1'b1; alarm_irq_en = 1'b1; run(200);
      alarm_irq_en = 1'b0; wd_steer = 1'b1; wd_zero = 1'b0; run(200);
      wd_zero = 1'b1;      run(200);
      wd_steer = 1'b0; wd_zero = 1'b0;
      // clear in mid-second
      cur_req = "R9";
      run(NOM / 2);
      pulse_clear();
      run(2 * NOM + 50);
      finish_run();
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

endmodule